// File: doc/BRIEF.md
# Equalizer Mode and Power-State Controller

This block sits between the configuration sources of a serial-video cable equalizer and its analog sections, and turns them into one consistent set of control levels. A mode input selects the source. In pin mode, dedicated pins supply the bypass level, the automatic sleep enable and the mute. In register mode, a small bank of configuration registers supplies these controls, and that bank is written through a simple word-write port. The block then applies a fixed ordering among power-down, mute and bypass. It gates the jitter cleaner from a detected-rate code, and it drives an enable for each output driver.

The jitter cleaner runs only when the rate detector reports a valid HD or 3G code and an internal acquisition state machine has reached its locked state. Every other case keeps the cleaner bypassed. Two self-clearing command bits sit in the control register. One restores every register and the state machine. The other restarts only the state machine, so software can force a re-lock without losing its configuration. All outputs come from one bank of flops that load on the same edge, so the analog side never sees a mixture of old and new controls.

Top module: `eqc_mode_ctrl`

## Requirements
- R1: With `modeSoft` low, the pins `hwBypassLvl`, `hwAutoSleep` and `hwMute` control the block and register contents have no effect. With `modeSoft` high, the register fields control the block and those pins have no effect.
- R2: `hwBypassLvl` is a decoded three-level pin. Code 00 (driven low) means normal operation. Code 01 (floating) bypasses only the jitter cleaner. Code 10 (driven high) bypasses both the equalizer and the jitter cleaner, and code 11 behaves like 10.
- R3: While power-down is requested, `eqPowerDown` is 1, `outMute` and `eqBypass` are 0, and `jcBypass` is 1, whatever the mute and bypass requests are.
- R4: When mute is requested without power-down, `outMute` is 1 and `eqBypass` is 0, even if equalizer bypass is also requested.
- R5: The sleep field sits in register 0 bits [3:2]. Code 00 keeps the equalizer on, 01 powers it down while `sigDet` is low, 10 forces power-down, and 11 acts like 01. In pin mode, `hwAutoSleep` high selects power-down while `sigDet` is low, and `hwAutoSleep` low keeps the equalizer on.
- R6: `jcBypass` is 0 only when `rateValid` is high and `rateCode` is 01 (HD) or 10 (3G). Code 00 (SD), code 11 and an invalid rate keep the cleaner bypassed. After an identified rate first appears, `jcBypass` falls on the second output update.
- R7: In register mode, register 0 bit 4 forces `jcBypass` to 1.
- R8: A write of register 0 with bit 7 set ignores the other bits of that word. It restores register 0 to 0x04 and register 1 to 0x0A and restarts the acquisition state machine. The bit reads as a one-cycle pulse and is never stored.
- R9: A write of register 0 with bit 6 set stores the other fields of that word and restarts only the acquisition state machine. With an identified rate present throughout, `jcBypass` is 1 on the second output update after the write edge, for exactly one cycle.
- R10: Register 1 holds a 2-bit swing field per driver, bits [1:0] for driver 0 and bits [3:2] for driver 1. In register mode a field of 00 clears that bit of `drvEn`. In pin mode both drivers are enabled. `out1Off` high clears `drvEn[1]` in both modes. Writes to addresses 2 and 3 change nothing.
- R11: Every output is registered and loads on the same clock edge. A change on a pin or register field appears at the outputs one cycle later.
- R12: While `rstN` is low, `eqPowerDown`=1, `outMute`=0, `eqBypass`=0, `jcBypass`=1 and `drvEn`=00. The registers hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSoft | input | 1 | 0: pin control, 1: register control |
| hwBypassLvl | input | 2 | Decoded three-level bypass pin |
| hwAutoSleep | input | 1 | Pin-mode automatic sleep enable |
| hwMute | input | 1 | Pin-mode output mute |
| out1Off | input | 1 | Disables output driver 1 in both modes |
| sigDet | input | 1 | Input signal present |
| rateCode | input | 2 | Detected rate: 00 SD, 01 HD, 10 3G, 11 none |
| rateValid | input | 1 | Rate code is meaningful |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address |
| cfgWdata | input | 8 | Register write data |
| eqPowerDown | output | 1 | Equalizer power-down |
| outMute | output | 1 | Output mute |
| eqBypass | output | 1 | Equalizer bypass |
| jcBypass | output | 1 | Jitter cleaner bypass and power-down |
| drvEn | output | 2 | Per-driver enable |

## Verification
On every cycle, the embedded assertions check the mutual exclusion of the power-down, mute and bypass outputs. They also check that the cleaner never runs without an identified rate present for the two preceding cycles, that the driver-1 pin always wins, and that the reset command pulses come only from matching writes and leave the registers at their defaults. Some behaviours are left to the directed scenarios: the meaning of each sleep and bypass code, which source is in control in each mode, and the exact update on which the acquisition restart removes the cleaner for one cycle. The scenarios also show that a master reset restores driver swings and mute while an acquisition restart keeps them.

// File: rtl/eqc_pkg.sv
package eqc_pkg;

  typedef enum logic [1:0] {
    SLP_ON   = 2'b00,
    SLP_AUTO = 2'b01,
    SLP_OFF  = 2'b10,
    SLP_RSVD = 2'b11
  } sleepMode_e;

  typedef enum logic [1:0] {
    ACQ_IDLE = 2'b00,
    ACQ_HUNT = 2'b01,
    ACQ_LOCK = 2'b10
  } acqState_e;

  // Rate detector codes
  localparam logic [1:0] RATE_SD   = 2'b00;
  localparam logic [1:0] RATE_HD   = 2'b01;
  localparam logic [1:0] RATE_3G   = 2'b10;
  localparam logic [1:0] RATE_NONE = 2'b11;

  // Pin-mode bypass level codes
  localparam logic [1:0] PIN_BYP_NONE = 2'b00;
  localparam logic [1:0] PIN_BYP_JC   = 2'b01;

  // Register 0 bit positions
  localparam int BIT_MUTE   = 0;
  localparam int BIT_BYPASS = 1;
  localparam int BIT_SLP_LO = 2;
  localparam int BIT_JCFORC = 4;
  localparam int BIT_ARST   = 6;
  localparam int BIT_MRST   = 7;

  typedef struct packed {
    logic       mute;
    logic       bypass;
    sleepMode_e sleepMode;
    logic       jcForce;
  } cfg_t;

  localparam cfg_t CFG_DEF = '{mute: 1'b0, bypass: 1'b0,
                               sleepMode: SLP_AUTO, jcForce: 1'b0};

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic masterClr;
    logic acqClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/eqc_ctrl.sv
module eqc_ctrl
  import eqc_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int NUM_DRV = 2,
  parameter int SWING_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [ADDR_W-1:0]           cfgAddr,
  input  logic [DATA_W-1:0]           cfgWdata,
  output cfg_t                        cfgQ,
  output logic [NUM_DRV*SWING_W-1:0]  swingQ,
  output ctrlStrobe_t                 strobeQ
);

  localparam int SW_TOT = NUM_DRV * SWING_W;
  localparam logic [SWING_W-1:0] SW_ONE = SWING_W'(2);
  localparam logic [SW_TOT-1:0]  SW_DEF = {NUM_DRV{SW_ONE}};
  localparam logic [ADDR_W-1:0]  ADDR_GEN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0]  ADDR_DRV = ADDR_W'(1);

  logic wrGen, wrDrv;
  logic unusedWdata;

  assign wrGen = cfgWe && (cfgAddr == ADDR_GEN);
  assign wrDrv = cfgWe && (cfgAddr == ADDR_DRV);
  assign unusedWdata = ^cfgWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= CFG_DEF;
      swingQ  <= SW_DEF;
      strobeQ <= '0;
    end else begin
      strobeQ <= '0;
      if (wrGen) begin
        if (cfgWdata[BIT_MRST]) begin
          cfgQ              <= CFG_DEF;
          swingQ            <= SW_DEF;
          strobeQ.masterClr <= 1'b1;
        end else begin
          cfgQ.mute      <= cfgWdata[BIT_MUTE];
          cfgQ.bypass    <= cfgWdata[BIT_BYPASS];
          cfgQ.sleepMode <= sleepMode_e'(cfgWdata[BIT_SLP_LO +: 2]);
          cfgQ.jcForce   <= cfgWdata[BIT_JCFORC];
          strobeQ.acqClr <= cfgWdata[BIT_ARST];
        end
      end else if (wrDrv) begin
        swingQ <= cfgWdata[SW_TOT-1:0];
      end
    end
  end

  // R8: a master pulse only follows a register-0 write with the master bit
  a_r8_master_src: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ.masterClr |-> ($past(cfgWe) && $past(cfgAddr) == ADDR_GEN
                           && $past(cfgWdata[BIT_MRST])));

  // R8: while the master pulse is visible the registers hold defaults
  a_r8_master_defaults: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ.masterClr |-> (cfgQ == CFG_DEF && swingQ == SW_DEF));

  // R9: an acquisition pulse follows a register-0 write with the acq bit
  a_r9_acq_src: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ.acqClr |-> ($past(cfgWe) && $past(cfgAddr) == ADDR_GEN
                        && $past(cfgWdata[BIT_ARST]) && !$past(cfgWdata[BIT_MRST])));

  // R8, R9: the two restart strobes never coincide
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeQ));

endmodule

// File: rtl/eqc_datapath.sv
module eqc_datapath
  import eqc_pkg::*;
#(
  parameter int NUM_DRV = 2,
  parameter int SWING_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        modeSoft,
  input  logic [1:0]                  hwBypassLvl,
  input  logic                        hwAutoSleep,
  input  logic                        hwMute,
  input  logic                        out1Off,
  input  logic                        sigDet,
  input  logic [1:0]                  rateCode,
  input  logic                        rateValid,
  input  cfg_t                        cfg,
  input  logic [NUM_DRV*SWING_W-1:0]  swing,
  input  ctrlStrobe_t                 strobe,
  output logic                        eqPowerDown,
  output logic                        outMute,
  output logic                        eqBypass,
  output logic                        jcBypass,
  output logic [NUM_DRV-1:0]          drvEn
);

  localparam int DRV1_IDX = 1;

  sleepMode_e sleepSel;
  logic pdReq, muteReq, bypAllReq, jcReq, rateOk, restart;
  logic [NUM_DRV-1:0] drvNext;
  acqState_e stateQ, stateNext;

  // Source selection (R1, R2, R5, R7)
  always_comb begin
    if (modeSoft) begin
      sleepSel  = (cfg.sleepMode == SLP_RSVD) ? SLP_AUTO : cfg.sleepMode;
      muteReq   = cfg.mute;
      bypAllReq = cfg.bypass;
      jcReq     = cfg.jcForce;
    end else begin
      sleepSel  = hwAutoSleep ? SLP_AUTO : SLP_ON;
      muteReq   = hwMute;
      bypAllReq = hwBypassLvl[1];
      jcReq     = (hwBypassLvl == PIN_BYP_JC);
    end
  end

  assign pdReq   = (sleepSel == SLP_OFF) || (sleepSel == SLP_AUTO && !sigDet);
  assign rateOk  = rateValid && (rateCode == RATE_HD || rateCode == RATE_3G);
  assign restart = strobe.masterClr || strobe.acqClr;

  // Acquisition state machine
  always_comb begin
    stateNext = stateQ;
    if (restart) begin
      stateNext = pdReq ? ACQ_IDLE : ACQ_HUNT;
    end else begin
      unique case (stateQ)
        ACQ_IDLE: if (!pdReq) stateNext = ACQ_HUNT;
        ACQ_HUNT: begin
          if (pdReq)       stateNext = ACQ_IDLE;
          else if (rateOk) stateNext = ACQ_LOCK;
        end
        ACQ_LOCK: begin
          if (pdReq)        stateNext = ACQ_IDLE;
          else if (!rateOk) stateNext = ACQ_HUNT;
        end
        default: stateNext = ACQ_IDLE;
      endcase
    end
  end

  // Driver enables, one per output
  for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
    logic swingOn;
    assign swingOn = |swing[i*SWING_W +: SWING_W];
    if (i == DRV1_IDX) begin : g_pin
      assign drvNext[i] = (modeSoft ? swingOn : 1'b1) && !out1Off;
    end else begin : g_reg
      assign drvNext[i] = modeSoft ? swingOn : 1'b1;
    end
  end

  // Single output bank, all loaded on one edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ACQ_IDLE;
      eqPowerDown <= 1'b1;
      outMute     <= 1'b0;
      eqBypass    <= 1'b0;
      jcBypass    <= 1'b1;
      drvEn       <= '0;
    end else begin
      stateQ      <= stateNext;
      eqPowerDown <= pdReq;
      outMute     <= !pdReq && muteReq;
      eqBypass    <= !pdReq && !muteReq && bypAllReq;
      jcBypass    <= pdReq || jcReq || bypAllReq || !(stateQ == ACQ_LOCK && rateOk);
      drvEn       <= drvNext;
    end
  end

  // R3: power-down excludes mute and bypass and stops the cleaner
  a_r3_sleep_wins: assert property (@(posedge clk) disable iff (!rstN)
    eqPowerDown |-> (!outMute && !eqBypass && jcBypass));

  // R4: mute excludes equalizer bypass
  a_r4_mute_wins: assert property (@(posedge clk) disable iff (!rstN)
    outMute |-> !eqBypass);

  // R6: a running cleaner implies an identified rate one cycle back
  a_r6_jc_rate: assert property (@(posedge clk) disable iff (!rstN)
    !jcBypass |-> ($past(rateValid) &&
                   ($past(rateCode) == RATE_HD || $past(rateCode) == RATE_3G)));

  // R6: the rate must also have been valid two cycles back (lock step)
  a_r6_jc_lock: assert property (@(posedge clk) disable iff (!rstN)
    !jcBypass |-> $past(rateValid, 2));

  // R5: forced power-down in register mode
  a_r5_force_off: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSoft) && $past(cfg.sleepMode) == SLP_OFF) |-> eqPowerDown);

  // R7: forced cleaner bypass in register mode
  a_r7_jc_force: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSoft) && $past(cfg.jcForce)) |-> jcBypass);

  // R10: the driver-1 pin always wins
  a_r10_pin_off: assert property (@(posedge clk) disable iff (!rstN)
    $past(out1Off) |-> !drvEn[DRV1_IDX]);

endmodule

// File: rtl/eqc_mode_ctrl.sv
module eqc_mode_ctrl
  import eqc_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int NUM_DRV = 2,
  parameter int SWING_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSoft,
  input  logic [1:0]         hwBypassLvl,
  input  logic               hwAutoSleep,
  input  logic               hwMute,
  input  logic               out1Off,
  input  logic               sigDet,
  input  logic [1:0]         rateCode,
  input  logic               rateValid,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  output logic               eqPowerDown,
  output logic               outMute,
  output logic               eqBypass,
  output logic               jcBypass,
  output logic [NUM_DRV-1:0] drvEn
);

  localparam int SW_TOT = NUM_DRV * SWING_W;

  cfg_t              cfgQ;
  logic [SW_TOT-1:0] swingQ;
  ctrlStrobe_t       strobeQ;

  eqc_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_DRV(NUM_DRV),
    .SWING_W(SWING_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgWdata(cfgWdata),
    .cfgQ    (cfgQ),
    .swingQ  (swingQ),
    .strobeQ (strobeQ)
  );

  eqc_datapath #(
    .NUM_DRV(NUM_DRV),
    .SWING_W(SWING_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .modeSoft   (modeSoft),
    .hwBypassLvl(hwBypassLvl),
    .hwAutoSleep(hwAutoSleep),
    .hwMute     (hwMute),
    .out1Off    (out1Off),
    .sigDet     (sigDet),
    .rateCode   (rateCode),
    .rateValid  (rateValid),
    .cfg        (cfgQ),
    .swing      (swingQ),
    .strobe     (strobeQ),
    .eqPowerDown(eqPowerDown),
    .outMute    (outMute),
    .eqBypass   (eqBypass),
    .jcBypass   (jcBypass),
    .drvEn      (drvEn)
  );

endmodule

// File: tb/eqc_mode_ctrl_bench.sv
`timescale 1ns/1ps
module eqc_mode_ctrl_bench;

  localparam real CLK_HALF = 2.5;
  localparam int  WDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rstN;
  logic modeSoft, hwAutoSleep, hwMute, out1Off, sigDet, rateValid, cfgWe;
  logic [1:0] hwBypassLvl, rateCode, cfgAddr;
  logic [7:0] cfgWdata;
  logic eqPowerDown, outMute, eqBypass, jcBypass;
  logic [1:0] drvEn;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_HALF) clk = ~clk;

  eqc_mode_ctrl u_eqc_mode_ctrl (
    .clk(clk), .rstN(rstN), .modeSoft(modeSoft), .hwBypassLvl(hwBypassLvl),
    .hwAutoSleep(hwAutoSleep), .hwMute(hwMute), .out1Off(out1Off),
    .sigDet(sigDet), .rateCode(rateCode), .rateValid(rateValid),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .eqPowerDown(eqPowerDown), .outMute(outMute), .eqBypass(eqBypass),
    .jcBypass(jcBypass), .drvEn(drvEn)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setIdle();
    modeSoft = 1'b0; hwBypassLvl = 2'b00; hwAutoSleep = 1'b0; hwMute = 1'b0;
    out1Off = 1'b0; sigDet = 1'b1; rateCode = 2'b11; rateValid = 1'b0;
    cfgWe = 1'b0; cfgAddr = 2'b00; cfgWdata = 8'h00;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
  endtask

  // R12: reset state
  task automatic t_reset();
    setIdle();
    rstN = 1'b0;
    tick(3);
    chk("R12", "eqPowerDown", {7'd0, eqPowerDown}, 8'd1);
    chk("R12", "outMute", {7'd0, outMute}, 8'd0);
    chk("R12", "eqBypass", {7'd0, eqBypass}, 8'd0);
    chk("R12", "jcBypass", {7'd0, jcBypass}, 8'd1);
    chk("R12", "drvEn", {6'd0, drvEn}, 8'd0);
    rstN = 1'b1;
    tick(3);
    chk("R12", "eqPowerDown after reset", {7'd0, eqPowerDown}, 8'd0);
    chk("R10", "hw drvEn", {6'd0, drvEn}, 8'd3);
  endtask

  // R2, R3, R4, R5 in pin mode
  task automatic t_hwMode();
    doReset();
    rateCode = 2'b01; rateValid = 1'b1;
    tick(4);
    chk("R2", "normal jcBypass", {7'd0, jcBypass}, 8'd0);
    hwBypassLvl = 2'b01; tick(2);
    chk("R2", "float eqBypass", {7'd0, eqBypass}, 8'd0);
    chk("R2", "float jcBypass", {7'd0, jcBypass}, 8'd1);
    hwBypassLvl = 2'b10; tick(2);
    chk("R2", "high eqBypass", {7'd0, eqBypass}, 8'd1);
    chk("R2", "high jcBypass", {7'd0, jcBypass}, 8'd1);
    hwBypassLvl = 2'b11; tick(2);
    chk("R2", "code11 eqBypass", {7'd0, eqBypass}, 8'd1);
    hwMute = 1'b1; tick(2);
    chk("R4", "mute over bypass mute", {7'd0, outMute}, 8'd1);
    chk("R4", "mute over bypass byp", {7'd0, eqBypass}, 8'd0);
    hwAutoSleep = 1'b1; sigDet = 1'b0; tick(2);
    chk("R3", "sleep eqPowerDown", {7'd0, eqPowerDown}, 8'd1);
    chk("R3", "sleep outMute", {7'd0, outMute}, 8'd0);
    chk("R3", "sleep eqBypass", {7'd0, eqBypass}, 8'd0);
    hwAutoSleep = 1'b0; tick(2);
    chk("R5", "autosleep low keeps on", {7'd0, eqPowerDown}, 8'd0);
    setIdle();
  endtask

  // R11: one-cycle output latency, lock adds one more
  task automatic t_latency();
    doReset();
    tick(2);
    hwMute = 1'b1;
    tick(1);
    chk("R11", "mute after one edge", {7'd0, outMute}, 8'd1);
    rateCode = 2'b10; rateValid = 1'b1;
    tick(1);
    chk("R6", "jc after one edge", {7'd0, jcBypass}, 8'd1);
    tick(1);
    chk("R6", "jc after two edges", {7'd0, jcBypass}, 8'd0);
    setIdle();
  endtask

  // R1, R5 in register mode
  task automatic t_softMode();
    doReset();
    wr(2'b00, 8'h05);                  // mute, sleep auto
    tick(2);
    chk("R1", "register mute ignored in pin mode", {7'd0, outMute}, 8'd0);
    modeSoft = 1'b1; tick(2);
    chk("R1", "register mute in reg mode", {7'd0, outMute}, 8'd1);
    wr(2'b00, 8'h04);
    hwMute = 1'b1; hwBypassLvl = 2'b10; tick(2);
    chk("R1", "pin mute ignored", {7'd0, outMute}, 8'd0);
    chk("R1", "pin bypass ignored", {7'd0, eqBypass}, 8'd0);
    sigDet = 1'b0; tick(2);
    chk("R5", "auto sleep no signal", {7'd0, eqPowerDown}, 8'd1);
    wr(2'b00, 8'h00); tick(1);
    chk("R5", "force on", {7'd0, eqPowerDown}, 8'd0);
    sigDet = 1'b1;
    wr(2'b00, 8'h08); tick(1);
    chk("R5", "force off", {7'd0, eqPowerDown}, 8'd1);
    wr(2'b00, 8'h0C); tick(1);
    chk("R5", "code11 with signal", {7'd0, eqPowerDown}, 8'd0);
    sigDet = 1'b0; tick(2);
    chk("R5", "code11 without signal", {7'd0, eqPowerDown}, 8'd1);
    sigDet = 1'b1;
    wr(2'b00, 8'h03); tick(1);
    chk("R4", "reg mute+bypass byp", {7'd0, eqBypass}, 8'd0);
    wr(2'b00, 8'h02); tick(1);
    chk("R2", "reg bypass eq", {7'd0, eqBypass}, 8'd1);
    chk("R2", "reg bypass jc", {7'd0, jcBypass}, 8'd1);
    setIdle();
  endtask

  // R6, R7 rate gating
  task automatic t_rate();
    doReset();
    modeSoft = 1'b1;
    wr(2'b00, 8'h00);
    rateValid = 1'b1;
    rateCode = 2'b00; tick(3);
    chk("R6", "SD bypassed", {7'd0, jcBypass}, 8'd1);
    rateCode = 2'b01; tick(3);
    chk("R6", "HD runs", {7'd0, jcBypass}, 8'd0);
    rateCode = 2'b10; tick(3);
    chk("R6", "3G runs", {7'd0, jcBypass}, 8'd0);
    rateCode = 2'b11; tick(3);
    chk("R6", "code11 bypassed", {7'd0, jcBypass}, 8'd1);
    rateCode = 2'b01; rateValid = 1'b0; tick(3);
    chk("R6", "invalid bypassed", {7'd0, jcBypass}, 8'd1);
    rateValid = 1'b1; tick(3);
    wr(2'b00, 8'h10); tick(1);
    chk("R7", "forced bypass", {7'd0, jcBypass}, 8'd1);
    setIdle();
  endtask

  // R10 driver enables
  task automatic t_drivers();
    doReset();
    modeSoft = 1'b1;
    tick(2);
    chk("R10", "default swings enable", {6'd0, drvEn}, 8'd3);
    wr(2'b01, 8'h0C); tick(1);
    chk("R10", "swing0 zero", {6'd0, drvEn}, 8'd2);
    wr(2'b10, 8'h00); tick(1);
    chk("R10", "addr2 ignored", {6'd0, drvEn}, 8'd2);
    out1Off = 1'b1; tick(1);
    chk("R10", "pin off reg mode", {6'd0, drvEn}, 8'd0);
    modeSoft = 1'b0; tick(1);
    chk("R10", "pin off pin mode", {6'd0, drvEn}, 8'd1);
    out1Off = 1'b0; modeSoft = 1'b1; tick(1);
  endtask

  // R8, R9 self-clearing restarts (continues from t_drivers register state)
  task automatic t_resets();
    rateCode = 2'b01; rateValid = 1'b1; sigDet = 1'b1;
    wr(2'b00, 8'h01);                  // mute, sleep on
    tick(3);
    chk("R9", "locked before restart", {7'd0, jcBypass}, 8'd0);
    wr(2'b00, 8'h41);                  // acq restart, keep mute
    tick(1);
    chk("R9", "first update still running", {7'd0, jcBypass}, 8'd0);
    tick(1);
    chk("R9", "second update bypassed", {7'd0, jcBypass}, 8'd1);
    tick(1);
    chk("R9", "relocked", {7'd0, jcBypass}, 8'd0);
    chk("R9", "mute kept", {7'd0, outMute}, 8'd1);
    chk("R9", "swing kept", {6'd0, drvEn}, 8'd2);
    wr(2'b00, 8'h83);                  // master, other bits ignored
    tick(1);
    chk("R8", "mute cleared", {7'd0, outMute}, 8'd0);
    chk("R8", "bypass ignored", {7'd0, eqBypass}, 8'd0);
    chk("R8", "swing restored", {6'd0, drvEn}, 8'd3);
    tick(1);
    chk("R8", "state restarted", {7'd0, jcBypass}, 8'd1);
    sigDet = 1'b0; tick(2);
    chk("R8", "sleep default auto", {7'd0, eqPowerDown}, 8'd1);
    setIdle();
  endtask

  initial begin
    #(CLK_HALF * 2.0 * WDOG_CYC);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    setIdle();
    t_reset();
    t_hwMode();
    t_latency();
    t_softMode();
    t_rate();
    t_drivers();
    t_resets();
    tick(2);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule